// File: doc/BRIEF.md
# Lockable Thermal Calibration Offset Register

This block holds the signed offset that trims a thermal sensor. Software sees one 8-bit register. Bit 7 is a sticky lock and bits 6:0 are a two's complement offset. The offset is sign-extended to the width of the temperature counter and added to the running counter value. The sum, which wraps, is the code presented to the sensor DAC.

Until software writes the offset, the effective offset is the value taken from the fuses. The first write made while the register is unlocked replaces it, and the fused value stays readable on its own output.

The lock and the offset live in separate reset domains. The lock is cleared only by the platform reset. The offset and its override flag are cleared only by the power-good reset. The lock is also exported so that neighbouring threshold controls can refuse writes while it is set.

Top module: `thermal_offset_reg`

## Requirements
- R1: After both resets, `rd_data[7]` and `lock_o` are 0, `rd_data[6:0]` equals `fuse_offset`, and `dac_code` equals `temp_count` plus the sign-extended `fuse_offset`.
- R2: A write with `wr_data[7]`=1 sets the lock from the next clock edge. A write with `wr_data[7]`=0 never clears it.
- R3: Only the platform reset (`plat_rst_n` low) clears the lock. The power-good reset leaves the lock unchanged.
- R4: The power-good reset (`pwr_rst_n` low) discards any software offset, so `rd_data[6:0]` returns to `fuse_offset`. The platform reset leaves the current offset unchanged.
- R5: While the lock is set, writes leave `rd_data[6:0]` and `dac_code` unchanged.
- R6: A write that sets the lock while the lock is still clear also loads its `wr_data[6:0]` as the offset.
- R7: After an unlocked write, `rd_data[6:0]` equals that write's `wr_data[6:0]` from the next edge on. Later changes of `fuse_offset` then have no effect on it.
- R8: The 7-bit offset is read as two's complement. Codes 00h to 3Fh mean +0 to +63, 40h means -64, and 41h to 7Fh mean -63 to -1. `dac_code` = (`temp_count` + offset) mod 512, combinationally, with no saturation.
- R9: `fuse_rdback` always equals `fuse_offset`, whatever has been written.
- R10: `lock_o` always equals `rd_data[7]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| plat_rst_n | input | 1 | Platform reset, active low, asynchronous; clears the lock |
| pwr_rst_n | input | 1 | Power-good reset, active low, asynchronous; clears the software offset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data: bit 7 requests the lock, bits 6:0 are the offset |
| rd_data | output | 8 | Read data: {lock, effective offset} |
| fuse_offset | input | 7 | Fused default offset |
| fuse_rdback | output | 7 | Fused offset readback |
| temp_count | input | 9 | Running temperature counter |
| dac_code | output | 9 | Adjusted code for the sensor DAC |
| lock_o | output | 1 | Lock state exported to related controls |

## Verification
The bench builds the block with its default widths: a 7-bit offset and a 9-bit counter and DAC code. These widths put the whole offset code space within reach, including the lone -64 code at 40h, both ends of the range, and counter values near 0 and 511 where the sum wraps. A reference model in the bench tracks the lock, the override flag and the offset. The bench applies each reset on its own, both before and after the lock is set, to show that the two reset domains stay independent.

// File: rtl/thermal_offset_pkg.sv
package thermal_offset_pkg;
    parameter int unsigned OFS_BITS = 7;
    parameter int unsigned DAC_BITS = 9;

    typedef struct packed {
        logic lock;
    } lock_state_t;

    typedef struct packed {
        logic                override;
        logic [OFS_BITS-1:0] sw_ofs;
    } ofs_state_t;
endpackage

// File: rtl/tco_lock_ctl.sv
module tco_lock_ctl (
    input  logic clk,
    input  logic plat_rst_n,
    input  logic wr_en,
    input  logic wr_lock_bit,
    output logic lock_q_o
);
    import thermal_offset_pkg::*;

    lock_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && wr_lock_bit) begin
            st_d.lock = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge plat_rst_n) begin
        if (!plat_rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lock_q_o = st_q.lock;

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!plat_rst_n)
        st_q.lock |=> st_q.lock); // R2

    AST_LOCK_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!plat_rst_n)
        $rose(st_q.lock) |-> $past(wr_en && wr_lock_bit)); // R2
endmodule

// File: rtl/tco_offset_store.sv
module tco_offset_store #(
    parameter int unsigned OFS_W = thermal_offset_pkg::OFS_BITS
) (
    input  logic             clk,
    input  logic             pwr_rst_n,
    input  logic             lock_i,
    input  logic             wr_en,
    input  logic [OFS_W-1:0] wr_ofs,
    input  logic [OFS_W-1:0] fuse_ofs,
    output logic [OFS_W-1:0] eff_ofs
);
    import thermal_offset_pkg::*;

    ofs_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && !lock_i) begin
            st_d.override = 1'b1;
            st_d.sw_ofs   = wr_ofs;
        end
    end

    always_ff @(posedge clk or negedge pwr_rst_n) begin
        if (!pwr_rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign eff_ofs = st_q.override ? st_q.sw_ofs : fuse_ofs;

    AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!pwr_rst_n)
        lock_i |=> ($stable(st_q.sw_ofs) && $stable(st_q.override))); // R5

    AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (!pwr_rst_n)
        (wr_en && !lock_i) |=> (st_q.override && st_q.sw_ofs == $past(wr_ofs))); // R7
endmodule

// File: rtl/tco_dac_adder.sv
module tco_dac_adder #(
    parameter int unsigned OFS_W = thermal_offset_pkg::OFS_BITS,
    parameter int unsigned DAC_W = thermal_offset_pkg::DAC_BITS
) (
    input  logic [OFS_W-1:0] ofs,
    input  logic [DAC_W-1:0] count,
    output logic [DAC_W-1:0] code
);
    localparam int unsigned EXT_W = DAC_W - OFS_W;

    logic [DAC_W-1:0] ofs_ext;

    always_comb begin
        ofs_ext = {{EXT_W{ofs[OFS_W-1]}}, ofs};
        code    = count + ofs_ext;
    end
endmodule

// File: rtl/thermal_offset_reg.sv
module thermal_offset_reg #(
    parameter int unsigned OFS_W = thermal_offset_pkg::OFS_BITS,
    parameter int unsigned DAC_W = thermal_offset_pkg::DAC_BITS
) (
    input  logic             clk,
    input  logic             plat_rst_n,
    input  logic             pwr_rst_n,
    input  logic             wr_en,
    input  logic [OFS_W:0]   wr_data,
    output logic [OFS_W:0]   rd_data,
    input  logic [OFS_W-1:0] fuse_offset,
    output logic [OFS_W-1:0] fuse_rdback,
    input  logic [DAC_W-1:0] temp_count,
    output logic [DAC_W-1:0] dac_code,
    output logic             lock_o
);
    localparam int unsigned EXT_W = DAC_W - OFS_W;

    logic             lock_q;
    logic [OFS_W-1:0] eff_ofs;

    tco_lock_ctl u_lock (
        .clk         (clk),
        .plat_rst_n  (plat_rst_n),
        .wr_en       (wr_en),
        .wr_lock_bit (wr_data[OFS_W]),
        .lock_q_o    (lock_q)
    );

    tco_offset_store #(.OFS_W(OFS_W)) u_store (
        .clk       (clk),
        .pwr_rst_n (pwr_rst_n),
        .lock_i    (lock_q),
        .wr_en     (wr_en),
        .wr_ofs    (wr_data[OFS_W-1:0]),
        .fuse_ofs  (fuse_offset),
        .eff_ofs   (eff_ofs)
    );

    tco_dac_adder #(.OFS_W(OFS_W), .DAC_W(DAC_W)) u_add (
        .ofs   (eff_ofs),
        .count (temp_count),
        .code  (dac_code)
    );

    assign rd_data     = {lock_q, eff_ofs};
    assign lock_o      = lock_q;
    assign fuse_rdback = fuse_offset;

    AST_DAC_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!plat_rst_n || !pwr_rst_n)
        (dac_code - temp_count) == {{EXT_W{rd_data[OFS_W-1]}}, rd_data[OFS_W-1:0]}); // R8

    AST_PWR_KEEPS_LOCK: assert property (@(posedge clk) disable iff (!plat_rst_n)
        lock_o |=> lock_o); // R3
endmodule

// File: tb/test_thermal_offset_reg.sv
module test_thermal_offset_reg;
    logic       clk = 1'b0;
    logic       plat_rst_n = 1'b0;
    logic       pwr_rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [6:0] fuse_offset = 7'h15;
    logic [6:0] fuse_rdback;
    logic [8:0] temp_count = '0;
    logic [8:0] dac_code;
    logic       lock_o;

    int n_cmp = 0;
    int n_bad = 0;

    // reference state
    int m_lock = 0;
    int m_ovr = 0;
    int m_ofs = 0;

    always #4 clk = ~clk;

    thermal_offset_reg i_thermal_offset_reg (
        .clk(clk), .plat_rst_n(plat_rst_n), .pwr_rst_n(pwr_rst_n),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .fuse_offset(fuse_offset), .fuse_rdback(fuse_rdback),
        .temp_count(temp_count), .dac_code(dac_code), .lock_o(lock_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int eff_model();
        return (m_ovr != 0) ? m_ofs : int'(fuse_offset);
    endfunction

    task automatic compare_all(input string req);
        int e, sv;
        e  = eff_model();
        sv = (e >= 64) ? e - 128 : e;
        check(req, "rd_data", int'(rd_data), (m_lock << 7) | e);
        check(req, "dac_code", int'(dac_code), (int'(temp_count) + sv + 512) % 512);
        check("R9", "fuse_rdback", int'(fuse_rdback), int'(fuse_offset));
        check("R10", "lock_o", int'(lock_o), int'(rd_data[7]));
    endtask

    // one clock: drive at negedge, compare, then model the edge
    task automatic step(input string req, input bit we, input int data, input int tc, input int fuse);
        @(negedge clk);
        wr_en       = we;
        wr_data     = data[7:0];
        temp_count  = tc[8:0];
        fuse_offset = fuse[6:0];
        #1;
        compare_all(req);
        @(posedge clk);
        if (we) begin
            if (m_lock == 0) begin
                m_ovr = 1;
                m_ofs = data & 8'h7f;
            end
            if ((data & 8'h80) != 0) m_lock = 1;
        end
    endtask

    task automatic do_reset(input string req, input bit plat, input bit pwr);
        @(negedge clk);
        wr_en = 1'b0;
        if (plat) begin plat_rst_n = 1'b0; m_lock = 0; end
        if (pwr)  begin pwr_rst_n = 1'b0; m_ovr = 0; m_ofs = 0; end
        #1;
        compare_all(req);
        @(negedge clk);
        plat_rst_n = 1'b1;
        pwr_rst_n  = 1'b1;
    endtask

    initial begin
        #1600000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        do_reset("R1", 1'b1, 1'b1);
        step("R1", 1'b0, 0, 100, 'h15);
        step("R1", 1'b0, 0, 3, 'h70);          // negative fuse value
        // R8: code space sweep with unlocked writes
        step("R8", 1'b1, 'h00, 0, 'h15);
        step("R8", 1'b1, 'h3f, 5, 'h15);
        step("R8", 1'b1, 'h40, 511, 'h15);
        step("R8", 1'b1, 'h41, 63, 'h15);
        step("R8", 1'b1, 'h7f, 0, 'h15);
        step("R8", 1'b1, 'h3f, 480, 'h15);
        step("R8", 1'b0, 0, 500, 'h15);        // wrap above 511
        // R7: fuse changes after override have no effect
        step("R7", 1'b0, 0, 10, 'h2a);
        step("R7", 1'b0, 0, 10, 'h55);
        // R2: lock bit 0 does not lock
        step("R2", 1'b1, 'h11, 7, 'h55);
        step("R2", 1'b0, 0, 7, 'h55);
        // R6: locking write also loads offset
        step("R6", 1'b1, 'h80 | 'h22, 7, 'h55);
        step("R6", 1'b0, 0, 7, 'h55);
        // R5: locked writes ignored; R2: zero does not unlock
        step("R5", 1'b1, 'h05, 9, 'h55);
        step("R5", 1'b1, 'h00, 9, 'h55);
        step("R2", 1'b0, 0, 9, 'h55);
        // R3/R4: power reset keeps lock, drops offset
        do_reset("R4", 1'b0, 1'b1);
        step("R3", 1'b0, 0, 20, 'h55);
        step("R5", 1'b1, 'h33, 20, 'h55);
        step("R4", 1'b0, 0, 20, 'h0c);
        // R3/R4: platform reset clears lock, keeps offset
        do_reset("R3", 1'b1, 1'b0);
        step("R3", 1'b1, 'h44, 20, 'h0c);
        step("R4", 1'b0, 0, 20, 'h0c);
        do_reset("R4", 1'b1, 1'b0);
        step("R4", 1'b0, 0, 30, 'h01);
        // random traffic
        for (int i = 0; i < 400; i++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 2) do_reset("R3", 1'b1, 1'b0);
            else if (r < 4) do_reset("R4", 1'b0, 1'b1);
            else step("R8", ($urandom_range(0, 3) == 0), int'($urandom_range(0, 127)) | ($urandom_range(0, 15) == 0 ? 'h80 : 0),
                      int'($urandom_range(0, 511)), int'($urandom_range(0, 127)));
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule